// File: doc/BRIEF.md
# Atomic Read-Modify-Write Engine

This block carries out one atomic memory operation at a time for a 64-bit register machine. Such an operation is encoded as a store-from-register instruction with the atomic addressing mode. The issuing pipeline presents several values on a one-cycle `start` strobe: the 8-bit opcode, the 32-bit immediate, the base register value, the 16-bit displacement, the source register value and the value of register zero (the fixed comparand register). The engine checks the encoding and forms the effective address. It then runs a locked read, compute and write sequence on a simple request/grant memory port.

The immediate selects the operation. Add, OR, AND and XOR each take an optional fetch bit (immediate bit 0) that returns the pre-update memory value to the source register. Exchange stores the source value and always returns the old value. Compare-exchange stores the source value only when memory equals the comparand, and it always returns the zero-extended old value to register zero. Both 32-bit and 64-bit widths are handled. A 32-bit operation works on the low halves of its operands and zero-extends what it returns.

When the sequence ends, `done` pulses for one cycle. Write-back enables and data for the source register and for register zero are valid during that pulse. An encoding the engine cannot execute finishes the same way, with `illegal` set, no memory access and no write-back.

Top module: `amo_engine`

## Requirements
- R1: Only opcode 0xC3 (32-bit) or 0xDB (64-bit) is accepted. These are class 3 in bits [2:0], mode 110 in bits [7:5], and size 00 or 11 in bits [4:3]. Any other opcode, byte and halfword sizes included, finishes with `illegal`=1 during the `done` pulse, makes no memory request and asserts neither write-back enable.
- R2: Only these 32-bit immediate values are accepted: 0x00/0x01 add, 0x40/0x41 OR, 0x50/0x51 AND, 0xA0/0xA1 XOR, 0xE1 exchange and 0xF1 compare-exchange. Any other immediate, including 0xE0 and 0xF0, is treated as in R1.
- R3: The memory address is the base value plus the displacement sign-extended from 16 bits, truncated to ADDR_W bits. The read and the write use that same address, and no other location changes.
- R4: Add, OR, AND and XOR store old op source. In 32-bit mode the operation uses only the low 32 bits, `mem_wide`=0, and only the low 32 bits of the location change.
- R5: When immediate bit 0 is set on add, OR, AND or XOR, `src_wb_en`=1 and `src_wb_data` is the old memory value, zero-extended in 32-bit mode. When bit 0 is clear, neither write-back enable is asserted.
- R6: Exchange stores the source value and returns the old value through `src_wb_en`/`src_wb_data`.
- R7: Compare-exchange stores the source value only when the old value equals register zero (low 32 bits only in 32-bit mode), and otherwise skips the write request. In both cases `r0_wb_en`=1 with the zero-extended old value, and `src_wb_en`=0.
- R8: `mem_lock` is high on every cycle `mem_req` is high. It stays high from the read request through the write grant, with no gap, and it is low while `done` is high.
- R9: A request holds its address, direction and write data until it is granted. `done` is a single-cycle pulse, `busy` is high from acceptance to `done`, and a `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Operation strobe; accepted only when idle |
| opcode | input | 8 | Instruction opcode byte |
| imm | input | 32 | Instruction immediate (operation select) |
| base_val | input | XLEN | Base register value |
| disp | input | 16 | Signed displacement |
| src_val | input | XLEN | Source register value |
| r0_val | input | XLEN | Register zero value (comparand) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Encoding rejected (valid with done) |
| mem_req | output | 1 | Memory request |
| mem_gnt | input | 1 | Memory grant; completes the request this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_wide | output | 1 | 1 = 64-bit access, 0 = low 32 bits |
| mem_lock | output | 1 | Exclusive hold on memory |
| mem_addr | output | ADDR_W | Access address |
| mem_wdata | output | XLEN | Write data |
| mem_rdata | input | XLEN | Read data, valid with the read grant |
| src_wb_en | output | 1 | Source register write-back enable |
| src_wb_data | output | XLEN | Source register write-back value |
| r0_wb_en | output | 1 | Register zero write-back enable |
| r0_wb_data | output | XLEN | Register zero write-back value |

## Verification
The bench builds the engine with ADDR_W = 8 and XLEN = 64. With only 256 addresses, the bench can hold the whole memory as an array and check the written location and its neighbour after every operation. Negative displacements wrap visibly in that space. The narrow address also keeps full sweeps over all 256 opcodes and all low immediate bytes affordable. Every legal operation runs at both widths against data patterns that split the halves, including comparands that match only in the low word.

// File: rtl/amo_pkg.sv
package amo_pkg;

    localparam logic [2:0] CLS_STORE_REG = 3'd3;
    localparam logic [2:0] MODE_ATOMIC   = 3'b110;
    localparam logic [1:0] SIZE_WORD     = 2'b00;
    localparam logic [1:0] SIZE_DWORD    = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_CALC,
        ST_WRITE,
        ST_UNLOCK,
        ST_DONE
    } amo_state_e;

    typedef enum logic [2:0] {
        OP_ADD,
        OP_OR,
        OP_AND,
        OP_XOR,
        OP_SWAP,
        OP_CSWAP
    } amo_op_e;

endpackage

// File: rtl/amo_decode.sv
module amo_decode
    import amo_pkg::*;
(
    input  logic [7:0]  opcode,
    input  logic [31:0] imm,
    output logic        legal,
    output logic        wide,
    output logic        fetch,
    output amo_op_e     op
);
    logic       opc_ok;
    logic       imm_ok;
    logic [1:0] size_f;

    always_comb begin
        size_f = opcode[4:3];
        opc_ok = (opcode[2:0] == CLS_STORE_REG) && (opcode[7:5] == MODE_ATOMIC)
                 && ((size_f == SIZE_WORD) || (size_f == SIZE_DWORD));
        wide   = (size_f == SIZE_DWORD);
        fetch  = imm[0];
        imm_ok = (imm[31:8] == 24'd0);
        op     = OP_ADD;
        unique case (imm[7:0])
            8'h00, 8'h01: op = OP_ADD;
            8'h40, 8'h41: op = OP_OR;
            8'h50, 8'h51: op = OP_AND;
            8'hA0, 8'hA1: op = OP_XOR;
            8'hE1:        op = OP_SWAP;
            8'hF1:        op = OP_CSWAP;
            default:      imm_ok = 1'b0;
        endcase
        legal = opc_ok && imm_ok;
    end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  amo_op_e         op,
    input  logic            wide,
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] src_val,
    input  logic [XLEN-1:0] cmp_val,
    output logic [XLEN-1:0] new_val,
    output logic            wr_en
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] opnd;
    logic [XLEN-1:0] res;
    logic            same;

    always_comb begin
        opnd = wide ? src_val : {{(XLEN-HALF){1'b0}}, src_val[HALF-1:0]};
        unique case (op)
            OP_ADD:  res = old_val + opnd;
            OP_OR:   res = old_val | opnd;
            OP_AND:  res = old_val & opnd;
            OP_XOR:  res = old_val ^ opnd;
            default: res = opnd;
        endcase
        new_val = wide ? res : {{(XLEN-HALF){1'b0}}, res[HALF-1:0]};
        same    = wide ? (old_val == cmp_val)
                       : (old_val[HALF-1:0] == cmp_val[HALF-1:0]);
        wr_en   = (op != OP_CSWAP) || same;
    end
endmodule

// File: rtl/amo_engine.sv
module amo_engine
    import amo_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int XLEN   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [31:0]       imm,
    input  logic [XLEN-1:0]   base_val,
    input  logic [15:0]       disp,
    input  logic [XLEN-1:0]   src_val,
    input  logic [XLEN-1:0]   r0_val,
    output logic              busy,
    output logic              done,
    output logic              illegal,
    output logic              mem_req,
    input  logic              mem_gnt,
    output logic              mem_we,
    output logic              mem_wide,
    output logic              mem_lock,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              src_wb_en,
    output logic [XLEN-1:0]   src_wb_data,
    output logic              r0_wb_en,
    output logic [XLEN-1:0]   r0_wb_data
);
    localparam int HALF  = XLEN / 2;
    localparam int DISPW = 16;

    typedef struct packed {
        amo_state_e        st;
        amo_op_e           op;
        logic              wide;
        logic              fetch;
        logic              bad;
        logic              wr_en;
        logic [ADDR_W-1:0] addr;
        logic [XLEN-1:0]   src;
        logic [XLEN-1:0]   cmp;
        logic [XLEN-1:0]   old;
        logic [XLEN-1:0]   wdata;
    } amo_regs_t;

    localparam amo_regs_t RESET_VAL = '{st: ST_IDLE, op: OP_ADD, default: '0};

    amo_regs_t q, d;

    logic            dec_legal;
    logic            dec_wide;
    logic            dec_fetch;
    amo_op_e         dec_op;
    logic [XLEN-1:0] alu_new;
    logic            alu_wr;
    logic [XLEN-1:0] eff_sum;

    amo_decode u_decode (
        .opcode (opcode),
        .imm    (imm),
        .legal  (dec_legal),
        .wide   (dec_wide),
        .fetch  (dec_fetch),
        .op     (dec_op)
    );

    amo_alu #(.XLEN(XLEN)) u_alu (
        .op      (q.op),
        .wide    (q.wide),
        .old_val (q.old),
        .src_val (q.src),
        .cmp_val (q.cmp),
        .new_val (alu_new),
        .wr_en   (alu_wr)
    );

    always_comb begin
        eff_sum = base_val + {{(XLEN-DISPW){disp[DISPW-1]}}, disp};
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.op    = dec_op;
                    d.wide  = dec_wide;
                    d.fetch = dec_fetch;
                    d.bad   = !dec_legal;
                    d.addr  = eff_sum[ADDR_W-1:0];
                    d.src   = src_val;
                    d.cmp   = r0_val;
                    d.old   = '0;
                    d.wr_en = 1'b0;
                    d.st    = dec_legal ? ST_READ : ST_DONE;
                end
            end
            ST_READ: begin
                if (mem_gnt) begin
                    d.old = q.wide ? mem_rdata
                                   : {{(XLEN-HALF){1'b0}}, mem_rdata[HALF-1:0]};
                    d.st  = ST_CALC;
                end
            end
            ST_CALC: begin
                d.wdata = alu_new;
                d.wr_en = alu_wr;
                d.st    = alu_wr ? ST_WRITE : ST_UNLOCK;
            end
            ST_WRITE: begin
                if (mem_gnt) begin
                    d.st = ST_UNLOCK;
                end
            end
            ST_UNLOCK: d.st = ST_DONE;
            default:   d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RESET_VAL;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        busy        = (q.st != ST_IDLE);
        done        = (q.st == ST_DONE);
        illegal     = done && q.bad;
        mem_req     = (q.st == ST_READ) || (q.st == ST_WRITE);
        mem_we      = (q.st == ST_WRITE);
        mem_lock    = (q.st == ST_READ) || (q.st == ST_CALC) || (q.st == ST_WRITE);
        mem_wide    = q.wide;
        mem_addr    = q.addr;
        mem_wdata   = q.wdata;
        src_wb_en   = done && !q.bad && q.fetch && (q.op != OP_CSWAP);
        r0_wb_en    = done && !q.bad && (q.op == OP_CSWAP);
        src_wb_data = q.old;
        r0_wb_data  = q.old;
    end
endmodule

// File: rtl/amo_engine_chk.sv
module amo_engine_chk #(
    parameter int ADDR_W = 64,
    parameter int XLEN   = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              illegal,
    input logic              mem_req,
    input logic              mem_gnt,
    input logic              mem_we,
    input logic              mem_lock,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [XLEN-1:0]   mem_wdata,
    input logic              src_wb_en,
    input logic              r0_wb_en
);
    AST_REQ_UNDER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_lock); // R8
    AST_DONE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_lock); // R8
    AST_WRITE_AFTER_LOCKED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> $past(mem_lock)); // R8
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata))); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R9
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> (!src_wb_en && !r0_wb_en)); // R1
    AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (src_wb_en || r0_wb_en) |-> done); // R5
    AST_CSWAP_NO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        r0_wb_en |-> !src_wb_en); // R7
endmodule

bind amo_engine amo_engine_chk #(.ADDR_W(ADDR_W), .XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .illegal   (illegal),
    .mem_req   (mem_req),
    .mem_gnt   (mem_gnt),
    .mem_we    (mem_we),
    .mem_lock  (mem_lock),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .src_wb_en (src_wb_en),
    .r0_wb_en  (r0_wb_en)
);

// File: tb/amo_engine_bench.sv
module amo_engine_bench;
    localparam int AW = 8;
    localparam int XL = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [7:0]    opcode = '0;
    logic [31:0]   imm = '0;
    logic [XL-1:0] base_val = '0;
    logic [15:0]   disp = '0;
    logic [XL-1:0] src_val = '0;
    logic [XL-1:0] r0_val = '0;
    logic          busy, done, illegal;
    logic          mem_req, mem_we, mem_wide, mem_lock;
    logic          mem_gnt = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [XL-1:0] mem_wdata;
    logic [XL-1:0] mem_rdata = '0;
    logic          src_wb_en, r0_wb_en;
    logic [XL-1:0] src_wb_data, r0_wb_data;

    always #5 clk = ~clk;

    amo_engine #(.ADDR_W(AW), .XLEN(XL)) u_amo_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .imm(imm),
        .base_val(base_val), .disp(disp), .src_val(src_val), .r0_val(r0_val),
        .busy(busy), .done(done), .illegal(illegal),
        .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_wide(mem_wide),
        .mem_lock(mem_lock), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .src_wb_en(src_wb_en), .src_wb_data(src_wb_data),
        .r0_wb_en(r0_wb_en), .r0_wb_data(r0_wb_data)
    );

    logic [XL-1:0] mem [256];
    int   checks = 0;
    int   errors = 0;
    int   grants = 0;
    int   writes = 0;
    int   lock_viol = 0;
    int   stall = 0;
    int   cycles = 0;
    logic [15:0] lfsr = 16'hACE1;

    // memory model: grant after a pseudo-random stall, act at the negedge
    always @(negedge clk) begin
        if (mem_req && !mem_lock) lock_viol++;
        if (mem_req) begin
            if (stall == 0) begin
                mem_gnt = 1'b1;
                mem_rdata = mem[mem_addr];
                if (mem_we) begin
                    if (mem_wide) mem[mem_addr] = mem_wdata;
                    else mem[mem_addr][31:0] = mem_wdata[31:0];
                    writes++;
                end
                grants++;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                stall = int'(lfsr[1:0]) % 3;
            end else begin
                mem_gnt = 1'b0;
                stall--;
            end
        end else begin
            mem_gnt = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog act=%0d exp=<150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    logic          r_ill, r_sen, r_ren;
    logic [XL-1:0] r_sdat, r_rdat;
    int            r_gr, r_wr, r_lv;

    task automatic run_op(input logic [7:0] opc, input logic [31:0] im, input logic [63:0] bv,
                          input logic [15:0] dp, input logic [63:0] sv, input logic [63:0] rv);
        int n, g0, w0, l0;
        @(negedge clk);
        g0 = grants; w0 = writes; l0 = lock_viol;
        opcode = opc; imm = im; base_val = bv; disp = dp; src_val = sv; r0_val = rv;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 500) begin
            @(negedge clk);
            n++;
        end
        if (!done) chk(1'b0, "R9 done timeout", 64'd0, 64'd1);
        r_ill = illegal; r_sen = src_wb_en; r_sdat = src_wb_data;
        r_ren = r0_wb_en; r_rdat = r0_wb_data;
        r_gr = grants - g0; r_wr = writes - w0; r_lv = lock_viol - l0;
        @(negedge clk);
        chk(!done, "R9 done single pulse", 64'(done), 64'd0);
    endtask

    function automatic bit imm_legal(input logic [31:0] im);
        return im inside {32'h00, 32'h01, 32'h40, 32'h41, 32'h50, 32'h51,
                          32'hA0, 32'hA1, 32'hE1, 32'hF1};
    endfunction

    logic [63:0] pats [4];
    logic [7:0]  ops [10];

    initial begin
        pats[0] = 64'h0000_0000_FFFF_FFFF;
        pats[1] = 64'h8000_0001_7FFF_FFFE;
        pats[2] = 64'hFFFF_FFFF_0000_0001;
        pats[3] = 64'h1234_5678_9ABC_DEF0;
        ops[0] = 8'h00; ops[1] = 8'h01; ops[2] = 8'h40; ops[3] = 8'h41; ops[4] = 8'h50;
        ops[5] = 8'h51; ops[6] = 8'hA0; ops[7] = 8'hA1; ops[8] = 8'hE1; ops[9] = 8'hF1;
        for (int i = 0; i < 256; i++) mem[i] = 64'h5555_0000_0000_0000 | 64'(i);

        repeat (3) @(negedge clk);
        // R9 reset state
        chk(!busy && !done && !mem_req && !mem_lock && !src_wb_en && !r0_wb_en,
            "R9 reset outputs", {58'd0, busy, done, mem_req, mem_lock, src_wb_en, r0_wb_en}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 opcode sweep
        for (int o = 0; o < 256; o++) begin
            bit exp_ill;
            exp_ill = !((o == 8'hC3) || (o == 8'hDB));
            run_op(8'(o), 32'h0, 64'h10, 16'h0, 64'h1, 64'h0);
            chk(r_ill == exp_ill, "R1 opcode legality", 64'(o), 64'(exp_ill));
            if (exp_ill)
                chk(r_gr == 0 && !r_sen && !r_ren, "R1 no access on illegal opcode",
                    64'(r_gr), 64'd0);
        end

        // R2 immediate sweep (low byte plus upper-bit cases)
        for (int k = 0; k < 260; k++) begin
            logic [31:0] im;
            bit exp_ill;
            im = (k < 256) ? 32'(k) : ((k == 256) ? 32'h100 : (k == 257) ? 32'h8000_0000
                 : (k == 258) ? 32'h0001_0001 : 32'hFFFF_FFA0);
            exp_ill = !imm_legal(im);
            run_op(8'hDB, im, 64'h20, 16'h0, 64'h3, 64'h0);
            chk(r_ill == exp_ill, "R2 immediate legality", 64'(im), 64'(exp_ill));
            chk((r_gr == 0) == exp_ill, "R2 access only when legal", 64'(r_gr), 64'(!exp_ill));
        end

        // R3..R8 functional sweep
        for (int oi = 0; oi < 10; oi++) begin
            for (int w = 0; w < 2; w++) begin
                for (int a = 0; a < 4; a++) begin
                    for (int b = 0; b < 4; b++) begin
                        logic [63:0] A, B, R, bv, old, bb, res, expmem, nb;
                        logic [15:0] dp;
                        logic [7:0]  ea, im8;
                        bit match, wr, esen, eren;
                        im8 = ops[oi];
                        A = pats[a];
                        B = pats[b] ^ 64'h0F0F_0000_0000_F0F0;
                        R = (b == 0) ? A : (b == 1) ? {~A[63:32], A[31:0]} : ~A;
                        bv = 64'hFFFF_FFFF_FFFF_FF00 + 64'(oi * 7 + a * 3 + b);
                        dp = (b[0]) ? 16'hFFF0 : 16'h0123;
                        ea = 8'(bv + {{48{dp[15]}}, dp});
                        mem[ea] = A;
                        nb = 64'hDEAD_BEEF_0000_0000 | 64'(oi);
                        mem[8'(ea + 8'd1)] = nb;
                        old = w ? A : {32'd0, A[31:0]};
                        bb  = w ? B : {32'd0, B[31:0]};
                        case (im8 & 8'hFE)
                            8'h00:   res = old + bb;
                            8'h40:   res = old | bb;
                            8'h50:   res = old & bb;
                            8'hA0:   res = old ^ bb;
                            default: res = bb;
                        endcase
                        match = w ? (A == R) : (A[31:0] == R[31:0]);
                        wr = (im8 != 8'hF1) || match;
                        expmem = !wr ? A : (w ? res : {A[63:32], res[31:0]});
                        esen = im8[0] && (im8 != 8'hF1);
                        eren = (im8 == 8'hF1);
                        run_op(w ? 8'hDB : 8'hC3, {24'd0, im8}, bv, dp, B, R);
                        chk(!r_ill, "R1 legal op accepted", 64'(r_ill), 64'd0);
                        if (im8 == 8'hE1) chk(mem[ea] == expmem, "R6 exchange stores source", mem[ea], expmem);
                        else if (im8 == 8'hF1) chk(mem[ea] == expmem, "R7 compare-exchange memory", mem[ea], expmem);
                        else chk(mem[ea] == expmem, "R4 arithmetic result", mem[ea], expmem);
                        chk(mem[8'(ea + 8'd1)] == nb, "R3 neighbour untouched", mem[8'(ea + 8'd1)], nb);
                        chk(r_wr == (wr ? 1 : 0), "R7 write skipped on mismatch", 64'(r_wr), 64'(wr));
                        chk(r_sen == esen, "R5 source write-back enable", 64'(r_sen), 64'(esen));
                        if (esen) chk(r_sdat == old, "R5 fetched old value", r_sdat, old);
                        chk(r_ren == eren, "R7 r0 write-back enable", 64'(r_ren), 64'(eren));
                        if (eren) chk(r_rdat == old, "R7 r0 old value", r_rdat, old);
                        chk(r_lv == 0, "R8 request only under lock", 64'(r_lv), 64'd0);
                    end
                end
            end
        end

        // R9 start while busy is ignored
        begin
            int n;
            mem[8'h40] = 64'd5;
            mem[8'h80] = 64'd7;
            @(negedge clk);
            opcode = 8'hDB; imm = 32'h0; base_val = 64'h40; disp = 16'h0; src_val = 64'd1;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            @(negedge clk);
            base_val = 64'h80; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            n = 0;
            while (!done && n < 500) begin @(negedge clk); n++; end
            repeat (12) @(negedge clk);
            chk(mem[8'h40] == 64'd6, "R9 first op completes", mem[8'h40], 64'd6);
            chk(mem[8'h80] == 64'd7, "R9 start while busy ignored", mem[8'h80], 64'd7);
            chk(!busy, "R9 idle afterwards", 64'(busy), 64'd0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule